// File: doc/BRIEF.md
# DAC Power Sequencing Controller

This block is the control state machine that brings a stereo converter from reset into playback and takes it back down again. It watches two reset levels (an external pin and an internal supply monitor), a master-clock-present flag, the valid and changed flags from the sample-rate ratio detector, the detected single-speed mode and a de-emphasis request. From these it drives the charge pump enable, the bias reference enable, the filter and modulator enable, the output pull-down release, the output mute and the effective de-emphasis enable.

The sequence walks through six states: reset, power-down, initialization, power-up, normal and mute. Analog thresholds are not sensed here; time in the power-up state is measured by counting a slow timer tick, and the number of ticks is a parameter chosen so that the path from reset release to audible output stays inside 50 ms.

Top module: `dac_pwr_seq`

## Requirements
- R1: While either reset input is low, all enables, the pull-down release and the de-emphasis enable are 0 and mute is 1 in the same cycle, and the controller returns to its reset state.
- R2: On the first clock with both resets high the controller leaves reset for power-down, where every enable is 0 and mute is 1 until the master-clock flag is seen high.
- R3: In initialization only the charge pump enable is 1; the controller stays there until the ratio-valid flag is high.
- R4: Ratio-valid high in initialization moves the controller to power-up, where charge pump, bias, filter/modulator and pull-down release are all 1 and mute stays 1.
- R5: Mute is 0 only in the normal state, with all four enables at 1.
- R6: Ratio-changed high in normal moves to the mute state (enables kept, mute 1); ratio-valid high with ratio-changed low then returns to normal.
- R7: Master-clock flag low in initialization, power-up, normal or mute moves the controller to power-down on the next clock.
- R8: The de-emphasis enable equals the request ANDed with the single-speed flag in normal and mute, and is 0 in every other state.
- R9: Power-up lasts exactly PUP_TICKS cycles in which tick is 1; cycles with tick 0 do not advance it, and the last counted tick moves it to normal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control clock |
| ext_rst_n | input | 1 | External reset level, active low |
| por_rst_n | input | 1 | Internal supply-monitor reset level, active low |
| mclk_ok | input | 1 | Master clock present |
| ratio_ok | input | 1 | Master/frame ratio valid |
| ratio_chg | input | 1 | Master/frame ratio has changed |
| single_speed | input | 1 | Detected rate is in the single-speed range |
| deemph_req | input | 1 | De-emphasis requested |
| tick | input | 1 | Slow timer tick, one cycle wide |
| cp_en | output | 1 | Charge pump enable |
| bias_en | output | 1 | Bias reference enable |
| mod_en | output | 1 | Interpolation filter and modulator enable |
| out_release | output | 1 | Release of the output pull-downs |
| mute | output | 1 | Output mute |
| deemph_en | output | 1 | Effective de-emphasis enable |

## Verification
The bench builds the controller with PUP_TICKS set to 4 and drives tick on alternate cycles, so the power-up dwell spans about eight clocks and the skipping of non-tick cycles is visible in every pass. The short dwell puts several full climbs within a short run: clock loss from initialization, power-up, normal and mute, a ratio change and recovery, and reset by either source mid-playback. De-emphasis request and speed flag are toggled in normal, mute and power-up to show the gating.

// File: rtl/dac_pwr_seq.sv
module dac_pwr_seq #(
  parameter int PUP_TICKS = 1000
) (
  input  logic clk,
  input  logic ext_rst_n,
  input  logic por_rst_n,
  input  logic mclk_ok,
  input  logic ratio_ok,
  input  logic ratio_chg,
  input  logic single_speed,
  input  logic deemph_req,
  input  logic tick,
  output logic cp_en,
  output logic bias_en,
  output logic mod_en,
  output logic out_release,
  output logic mute,
  output logic deemph_en
);
  localparam int CW = (PUP_TICKS < 2) ? 1 : $clog2(PUP_TICKS);
  localparam logic [CW-1:0] LAST = CW'(PUP_TICKS - 1);

  typedef enum logic [2:0] {S_RST, S_PDN, S_INIT, S_PUP, S_NORM, S_MUTE} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          rst_act;
  logic          live;

  assign rst_act = ~(ext_rst_n & por_rst_n);

  always_ff @(posedge clk or posedge rst_act) begin
    if (rst_act) begin
      st  <= S_RST;
      cnt <= '0;
    end else begin
      case (st)
        S_RST: st <= S_PDN;
        S_PDN: if (mclk_ok) st <= S_INIT;
        S_INIT:
          if (!mclk_ok) st <= S_PDN;
          else if (ratio_ok) begin
            st  <= S_PUP;
            cnt <= '0;
          end
        S_PUP:
          if (!mclk_ok) st <= S_PDN;
          else if (tick) begin
            if (cnt == LAST) st <= S_NORM;
            else cnt <= cnt + 1'b1;
          end
        S_NORM:
          if (!mclk_ok) st <= S_PDN;
          else if (ratio_chg) st <= S_MUTE;
        S_MUTE:
          if (!mclk_ok) st <= S_PDN;
          else if (ratio_ok && !ratio_chg) st <= S_NORM;
        default: st <= S_RST;
      endcase
    end
  end

  assign live        = (st == S_PUP) || (st == S_NORM) || (st == S_MUTE);
  assign cp_en       = ~rst_act & (live || st == S_INIT);
  assign bias_en     = ~rst_act & live;
  assign mod_en      = ~rst_act & live;
  assign out_release = ~rst_act & live;
  assign mute        = rst_act | (st != S_NORM);
  assign deemph_en   = ~rst_act & deemph_req & single_speed &
                       ((st == S_NORM) || (st == S_MUTE));

  AST_CLKLOSS_PDN: assert property (@(posedge clk) disable iff (rst_act)
    (cp_en && !mclk_ok) |=> !cp_en && mute); // R7
  AST_PUP_AFTER_INIT: assert property (@(posedge clk) disable iff (rst_act)
    $rose(bias_en) |-> $past(cp_en) && $past(ratio_ok)); // R4
  AST_CHG_MUTES: assert property (@(posedge clk) disable iff (rst_act)
    (!mute && ratio_chg && mclk_ok) |=> mute && bias_en); // R6
  AST_UNMUTE_POWERED: assert property (@(posedge clk) disable iff (rst_act)
    !mute |-> cp_en && bias_en && mod_en && out_release); // R5
  AST_DEEMPH_GATED: assert property (@(posedge clk) disable iff (rst_act)
    deemph_en |-> single_speed && out_release); // R8
  AST_CP_ONLY_INIT: assert property (@(posedge clk) disable iff (rst_act)
    (cp_en && !bias_en) |-> mute && !out_release); // R3
endmodule

// File: tb/dac_pwr_seq_test.sv
module dac_pwr_seq_test;
  localparam int PT = 4;

  logic clk = 0;
  logic ext_rst_n = 0, por_rst_n = 0, mclk_ok = 0, ratio_ok = 0, ratio_chg = 0;
  logic single_speed = 0, deemph_req = 0, tick = 0;
  logic cp_en, bias_en, mod_en, out_release, mute, deemph_en;

  int checks = 0, errors = 0, cyc = 0;
  int ph = 0, tk = 0;
  bit lost = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dac_pwr_seq #(.PUP_TICKS(PT)) uut (
    .clk(clk), .ext_rst_n(ext_rst_n), .por_rst_n(por_rst_n), .mclk_ok(mclk_ok),
    .ratio_ok(ratio_ok), .ratio_chg(ratio_chg), .single_speed(single_speed),
    .deemph_req(deemph_req), .tick(tick), .cp_en(cp_en), .bias_en(bias_en),
    .mod_en(mod_en), .out_release(out_release), .mute(mute), .deemph_en(deemph_en)
  );

  // reference: ph 0 reset, 1 power-down, 2 init, 3 power-up, 4 normal, 5 mute
  always @(posedge clk) begin
    lost = 0;
    if (!(ext_rst_n && por_rst_n)) ph = 0;
    else if (ph == 0) ph = 1;
    else if (ph == 1) begin if (mclk_ok) ph = 2; end
    else if (!mclk_ok) begin ph = 1; lost = 1; end
    else if (ph == 2) begin if (ratio_ok) begin ph = 3; tk = 0; end end
    else if (ph == 3) begin
      if (tick) begin tk++; if (tk == PT) ph = 4; end
    end
    else if (ph == 4) begin if (ratio_chg) ph = 5; end
    else if (ph == 5) begin if (ratio_ok && !ratio_chg) ph = 4; end
  end

  task automatic compare();
    bit r = ext_rst_n && por_rst_n;
    bit e_cp = r && ph >= 2;
    bit e_on = r && ph >= 3;
    bit e_mu = !(r && ph == 4);
    bit e_de = r && deemph_req && single_speed && (ph == 4 || ph == 5);
    string tag;
    if (!r) tag = "R1";
    else if (lost) tag = "R7";
    else case (ph)
      0, 1: tag = "R2";
      2: tag = "R3";
      3: tag = "R4/R9";
      4: tag = "R5";
      default: tag = "R6";
    endcase
    checks++;
    if ({cp_en, bias_en, mod_en, out_release, mute} != {e_cp, e_on, e_on, e_on, e_mu}) begin
      errors++;
      $display("FAIL %s cyc %0d: cp/bias/mod/rel/mute act %b exp %b", tag, cyc,
               {cp_en, bias_en, mod_en, out_release, mute}, {e_cp, e_on, e_on, e_on, e_mu});
    end
    checks++;
    if (deemph_en !== e_de) begin
      errors++;
      $display("FAIL R8 cyc %0d: deemph_en act %b exp %b", cyc, deemph_en, e_de);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
      cyc++;
      compare();
      tick = cyc[0];
    end
  endtask

  task automatic climb();
    mclk_ok = 1; step(3);                       // R3 wait in init
    ratio_ok = 1; step(12);                     // R4, R9 dwell
  endtask

  initial begin
    step(3);                                    // R1 both resets low
    ext_rst_n = 1; step(2);                     // R1 internal still low
    por_rst_n = 1; step(4);                     // R2 idle in power-down
    climb();                                    // R5 normal reached
    deemph_req = 1; step(2);                    // R8 not single speed
    single_speed = 1; step(2);                  // R8 active
    ratio_chg = 1; ratio_ok = 0; step(1);       // R6
    ratio_chg = 0; step(3);                     // R6 held muted
    ratio_ok = 1; step(3);                      // R6 back to normal
    mclk_ok = 0; step(3);                       // R7 from normal
    mclk_ok = 1; ratio_ok = 0; step(2);
    mclk_ok = 0; step(2);                       // R7 from init
    climb();
    ratio_chg = 1; step(1); ratio_chg = 0; ratio_ok = 0; step(2);
    mclk_ok = 0; step(2);                       // R7 from mute
    mclk_ok = 1; step(2); ratio_ok = 1; step(4);
    mclk_ok = 0; step(2);                       // R7 from power-up
    climb();
    por_rst_n = 0; step(2);                     // R1 internal reset alone
    por_rst_n = 1; step(2);
    climb();
    ext_rst_n = 0; step(2);                     // R1 external reset alone
    ext_rst_n = 1; deemph_req = 0; step(16);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: act hung exp finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule